// File: doc/BRIEF.md
# Transport Stream Output Formatter

This block sits at the end of a cable-receiver datapath. It takes bytes of 188-byte transport packets from the error-correction stage and turns them into pin-level transport-stream signals. Each byte arrives on a valid/ready handshake, with a start-of-packet marker on the first byte of every packet. The first byte of a packet also carries a flag that says whether error correction failed on that packet. The block produces an output clock, a byte-wide data bus, a data-valid strobe, a packet-sync pulse and a packet-error indicator.

A static mode input chooses between two formats. In parallel mode one byte goes out per output-clock period. In serial mode the byte is sent most significant bit first on data line 0, one bit per output-clock period. A second static input enables error-indicator insertion: in a packet flagged uncorrectable, bit 7 of the byte that follows the sync byte is forced high. The output clock runs at half the core clock rate and never stops. Every output changes on the core edge where the output clock falls, so the outputs are stable at each rising edge of the output clock.

Top module: `ts_out_formatter`

## Requirements
- R1: While reset is held, `ts_clk`, `ts_valid`, `ts_sync`, `ts_err` and `in_ready` are all low.
- R2: After reset, `ts_clk` changes level on every core clock edge, including while no input is offered.
- R3: In parallel mode each accepted byte appears on `ts_data[7:0]` with `ts_valid` high for exactly one output-clock period. Bytes appear in acceptance order. Outputs change only on the edge that drives `ts_clk` low. An unbroken input stream is accepted at one byte every 2 core cycles.
- R4: `ts_sync` is high for exactly the byte accepted with `in_sop` = 1, whatever that byte's value, and the byte is passed through unchanged. It is low for every other byte.
- R5: `in_uncor` is sampled only on the start-of-packet byte. `ts_err` is high for every one of the PKT_LEN bytes of a packet flagged with `in_uncor` = 1. It is low for bytes of clean packets and for bytes that arrive without `in_sop` after a packet has ended.
- R6: When `cfg_err_ins` = 1 and the packet is flagged uncorrectable, the byte at position 1 (right after the start byte) leaves with bit 7 set to 1. Every other byte is unchanged, and nothing is altered when `cfg_err_ins` = 0 or the packet is clean.
- R7: If no byte is available when the output clock falls, `ts_valid`, `ts_sync` and `ts_err` go low for that period.
- R8: With `cfg_serial` = 1, each byte is sent bit 7 first on `ts_data[0]`, one bit per output-clock period, with `ts_data[7:1]` = 0 and `ts_valid` high for 8 consecutive periods.
- R9: In serial mode `ts_sync` and `ts_err` keep their value for all 8 bit periods of a byte.
- R10: In serial mode `in_ready` stays low while a byte is being shifted out. An unbroken input stream is accepted at one byte every 16 core cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_serial | input | 1 | 1 selects serial bit output, 0 parallel bytes |
| cfg_err_ins | input | 1 | 1 enables error-indicator insertion |
| in_valid | input | 1 | Input byte is offered |
| in_ready | output | 1 | Formatter takes the byte at this edge |
| in_data | input | 8 | Input byte |
| in_sop | input | 1 | Input byte is the first of a packet |
| in_uncor | input | 1 | Packet uncorrectable (sampled with in_sop) |
| ts_clk | output | 1 | Output clock, half the core rate |
| ts_data | output | 8 | Output byte, or serial bit on bit 0 |
| ts_valid | output | 1 | Output data valid |
| ts_sync | output | 1 | Start-byte pulse |
| ts_err | output | 1 | Uncorrectable-packet indicator |

## Verification
The bench drives `in_uncor` inverted on every byte other than the start byte. A formatter that sampled the flag per byte would then toggle `ts_err` inside a packet. It sends packets two bytes longer than PKT_LEN. A wrong end-of-packet count would keep `ts_err` high past the packet or force bit 7 in the wrong place. It uses a start byte other than 0x47 to catch a design that decodes the sync value instead of the marker. It also times handshakes in serial mode: accepting early would overwrite a byte that is still being shifted, and a stall would break the 16-cycle cadence.

// File: rtl/ts_fmt_pkg.sv
package ts_fmt_pkg;

    localparam int TS_BYTE_W    = 8;
    localparam int TS_BIT_CNT_W = $clog2(TS_BYTE_W);
    localparam logic [TS_BYTE_W-1:0] TS_TEI_MASK = {1'b1, {(TS_BYTE_W-1){1'b0}}};

    typedef struct packed {
        logic                    oclk;
    } clk_state_t;

    typedef struct packed {
        logic [TS_BYTE_W-1:0]    dout;
        logic                    den;
        logic                    psync;
        logic                    perr;
        logic [TS_BYTE_W-2:0]    shreg;
        logic [TS_BIT_CNT_W-1:0] left;
    } out_state_t;

endpackage

// File: rtl/ts_fmt_clkgen.sv
module ts_fmt_clkgen
    import ts_fmt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic oclk
);

    clk_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.oclk = ~s_q.oclk;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign oclk = s_q.oclk;

endmodule

// File: rtl/ts_fmt_tracker.sv
module ts_fmt_tracker
    import ts_fmt_pkg::*;
#(
    parameter int PKT_LEN = 188
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 accept,
    input  logic                 sop,
    input  logic                 uncor_in,
    input  logic                 tei_en,
    input  logic [TS_BYTE_W-1:0] byte_in,
    output logic [TS_BYTE_W-1:0] byte_out,
    output logic                 err_out
);

    localparam int POS_W = $clog2(PKT_LEN);

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic             unc;
    } trk_state_t;

    trk_state_t s_d, s_q;
    logic       in_pkt;
    logic       force_tei;

    always_comb begin
        s_d       = s_q;
        in_pkt    = (s_q.pos != '0);
        force_tei = tei_en && !sop && s_q.unc && (s_q.pos == POS_W'(1));
        err_out   = sop ? uncor_in : (in_pkt && s_q.unc);
        byte_out  = force_tei ? (byte_in | TS_TEI_MASK) : byte_in;
        if (accept) begin
            if (sop) begin
                s_d.pos = POS_W'(1);
                s_d.unc = uncor_in;
            end else if (in_pkt) begin
                if (s_q.pos == POS_W'(PKT_LEN - 1)) begin
                    s_d.pos = '0;
                    s_d.unc = 1'b0;
                end else begin
                    s_d.pos = s_q.pos + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.pos < POS_W'(PKT_LEN)); // R5

    AST_IDLE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.pos == '0) |-> !s_q.unc); // R5

endmodule

// File: rtl/ts_fmt_outstage.sv
module ts_fmt_outstage
    import ts_fmt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 adv,
    input  logic                 serial,
    input  logic                 in_valid,
    input  logic [TS_BYTE_W-1:0] byte_in,
    input  logic                 sync_in,
    input  logic                 err_in,
    output logic                 ready,
    output logic [TS_BYTE_W-1:0] dout,
    output logic                 den,
    output logic                 psync,
    output logic                 perr
);

    out_state_t s_d, s_q;

    always_comb begin
        s_d   = s_q;
        ready = adv && (s_q.left == '0);
        if (adv) begin
            if (s_q.left != '0) begin
                s_d.dout  = {{(TS_BYTE_W-1){1'b0}}, s_q.shreg[TS_BYTE_W-2]};
                s_d.shreg = {s_q.shreg[TS_BYTE_W-3:0], 1'b0};
                s_d.left  = s_q.left - 1'b1;
            end else if (in_valid) begin
                s_d.den   = 1'b1;
                s_d.psync = sync_in;
                s_d.perr  = err_in;
                if (serial) begin
                    s_d.dout  = {{(TS_BYTE_W-1){1'b0}}, byte_in[TS_BYTE_W-1]};
                    s_d.shreg = byte_in[TS_BYTE_W-2:0];
                    s_d.left  = TS_BIT_CNT_W'(TS_BYTE_W - 1);
                end else begin
                    s_d.dout  = byte_in;
                end
            end else begin
                s_d.den   = 1'b0;
                s_d.psync = 1'b0;
                s_d.perr  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dout  = s_q.dout;
    assign den   = s_q.den;
    assign psync = s_q.psync;
    assign perr  = s_q.perr;

    AST_SYNC_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.psync |-> s_q.den); // R4

    AST_ERR_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.perr |-> s_q.den); // R5

    AST_SHIFT_HOLDS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.left != '0) |=> ($stable(s_q.psync) && $stable(s_q.perr) && s_q.den)); // R9

endmodule

// File: rtl/ts_out_formatter.sv
module ts_out_formatter
    import ts_fmt_pkg::*;
#(
    parameter int PKT_LEN = 188
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_serial,
    input  logic                 cfg_err_ins,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [TS_BYTE_W-1:0] in_data,
    input  logic                 in_sop,
    input  logic                 in_uncor,
    output logic                 ts_clk,
    output logic [TS_BYTE_W-1:0] ts_data,
    output logic                 ts_valid,
    output logic                 ts_sync,
    output logic                 ts_err
);

    logic                 oclk;
    logic                 xfer;
    logic [TS_BYTE_W-1:0] mod_byte;
    logic                 byte_err;

    assign xfer   = in_valid && in_ready;
    assign ts_clk = oclk;

    ts_fmt_clkgen i_clkgen (
        .clk  (clk),
        .rst_n(rst_n),
        .oclk (oclk)
    );

    ts_fmt_tracker #(.PKT_LEN(PKT_LEN)) i_tracker (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (xfer),
        .sop     (in_sop),
        .uncor_in(in_uncor),
        .tei_en  (cfg_err_ins),
        .byte_in (in_data),
        .byte_out(mod_byte),
        .err_out (byte_err)
    );

    ts_fmt_outstage i_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (oclk),
        .serial  (cfg_serial),
        .in_valid(in_valid),
        .byte_in (mod_byte),
        .sync_in (in_sop),
        .err_in  (byte_err),
        .ready   (in_ready),
        .dout    (ts_data),
        .den     (ts_valid),
        .psync   (ts_sync),
        .perr    (ts_err)
    );

    AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ts_data) |-> !ts_clk); // R3

    AST_VALID_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ts_valid) |-> !ts_clk); // R3

    AST_READY_SERIAL: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && cfg_serial) |=> ##1 !in_ready); // R10

endmodule

// File: tb/test_ts_out_formatter.sv
module test_ts_out_formatter;

    localparam int PKT    = 188;
    localparam int N_ROWS = 6;
    // {serial, err_ins, uncor, start_byte[7:0], length[8:0], gap[3:0]}
    localparam logic [23:0] ROWS [N_ROWS] = '{
        {1'b0, 1'b0, 1'b0, 8'h47, 9'd188, 4'd0},
        {1'b0, 1'b1, 1'b1, 8'h47, 9'd190, 4'd0},
        {1'b0, 1'b0, 1'b1, 8'h47, 9'd188, 4'd2},
        {1'b0, 1'b1, 1'b0, 8'h12, 9'd188, 4'd1},
        {1'b1, 1'b1, 1'b1, 8'h47, 9'd190, 4'd0},
        {1'b1, 1'b0, 1'b0, 8'hB8, 9'd188, 4'd3}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_serial = 1'b0;
    logic       cfg_err_ins = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = 8'h00;
    logic       in_sop = 1'b0;
    logic       in_uncor = 1'b0;
    logic       ts_clk;
    logic [7:0] ts_data;
    logic       ts_valid;
    logic       ts_sync;
    logic       ts_err;

    always #10 clk = ~clk;

    ts_out_formatter #(.PKT_LEN(PKT)) i_ts_out_formatter (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_serial (cfg_serial),
        .cfg_err_ins(cfg_err_ins),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_data    (in_data),
        .in_sop     (in_sop),
        .in_uncor   (in_uncor),
        .ts_clk     (ts_clk),
        .ts_data    (ts_data),
        .ts_valid   (ts_valid),
        .ts_sync    (ts_sync),
        .ts_err     (ts_err)
    );

    int         checks = 0;
    int         fails  = 0;
    int         cyc    = 0;
    int         hs_cyc = 0;
    bit         done   = 1'b0;
    logic [9:0] exp_q [$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp, input string what);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic take(input logic [7:0] d, input logic s, input logic e);
        logic [9:0] x;
        if (exp_q.size() == 0) begin
            check(1'b0, "R3", {22'd0, s, e, d}, 32'd0, "byte with none expected");
        end else begin
            x = exp_q.pop_front();
            check(x == {s, e, d},
                  (x[9] != s) ? "R4" : (x[8] != e) ? "R5" : "R3/R6",
                  {22'd0, s, e, d}, {22'd0, x}, "output byte {sync,err,data}");
        end
    endtask

    // monitor: one sample per output-clock period, in its high phase
    logic [10:0] lo_smp;
    bit          have_lo = 1'b0;
    logic [7:0]  acc;
    int          bitn = 0;
    logic        s0, e0;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (!ts_clk) begin
                lo_smp  = {ts_data, ts_valid, ts_sync, ts_err};
                have_lo = 1'b1;
            end else begin
                if (have_lo && ts_valid)
                    check(lo_smp == {ts_data, ts_valid, ts_sync, ts_err}, "R3",
                          {21'd0, ts_data, ts_valid, ts_sync, ts_err}, {21'd0, lo_smp},
                          "outputs moved at ts_clk rise");
                if (ts_valid) begin
                    if (cfg_serial) begin
                        check(ts_data[7:1] == 7'd0, "R8", ts_data, {31'd0, ts_data[0]},
                              "upper lines in serial mode");
                        if (bitn == 0) begin
                            s0 = ts_sync;
                            e0 = ts_err;
                        end else begin
                            check({ts_sync, ts_err} == {s0, e0}, "R9",
                                  {30'd0, ts_sync, ts_err}, {30'd0, s0, e0},
                                  "flags within serial byte");
                        end
                        acc = {acc[6:0], ts_data[0]};
                        bitn++;
                        if (bitn == 8) begin
                            take(acc, s0, e0);
                            bitn = 0;
                        end
                    end else begin
                        take(ts_data, ts_sync, ts_err);
                    end
                end else begin
                    check(!ts_sync && !ts_err, "R7", {30'd0, ts_sync, ts_err}, 32'd0,
                          "flags while not valid");
                    if (cfg_serial && bitn != 0) begin
                        check(1'b0, "R8", bitn, 8, "valid dropped inside serial byte");
                        bitn = 0;
                    end
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!done && cyc > 150000) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    task automatic send_byte(input logic [7:0] b, input logic s, input logic u);
        in_data  = b;
        in_sop   = s;
        in_uncor = u;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        hs_cyc = cyc;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        logic [23:0] row;
        logic [7:0]  b, d;
        logic        prev_clk;
        int          prev_hs, guard, v, glen, gapn;

        // R1: reset state
        repeat (5) @(negedge clk);
        check({ts_clk, ts_valid, ts_sync, ts_err, in_ready} == 5'd0, "R1",
              {27'd0, ts_clk, ts_valid, ts_sync, ts_err, in_ready}, 32'd0, "reset outputs");
        rst_n = 1'b1;

        // R2 / R7: clock runs while idle, nothing valid
        prev_clk = ts_clk;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check(ts_clk != prev_clk, "R2", ts_clk, !prev_clk, "ts_clk toggle while idle");
            check(!ts_valid && !ts_sync && !ts_err, "R7",
                  {29'd0, ts_valid, ts_sync, ts_err}, 32'd0, "idle outputs");
            prev_clk = ts_clk;
        end

        for (int r = 0; r < N_ROWS; r++) begin
            row         = ROWS[r];
            cfg_serial  = row[23];
            cfg_err_ins = row[22];
            glen        = int'(row[12:4]);
            gapn        = int'(row[3:0]);
            @(negedge clk);
            prev_hs = 0;
            for (int k = 0; k < glen; k++) begin
                repeat (gapn) @(negedge clk);
                v = ((k * 29) + (r * 11)) ^ 32'hA5;
                b = v[7:0];
                if (k == 1) b[7] = 1'b0;
                if (k == 0) b = row[20:13];
                d = b;
                if (k == 1 && row[21] && row[22]) d[7] = 1'b1;       // R6
                exp_q.push_back({k == 0, row[21] && (k < PKT), d});   // R4 R5
                send_byte(b, k == 0, (k == 0) ? row[21] : !row[21]);
                if (gapn == 0 && k > 0) begin
                    if (row[23])
                        check(hs_cyc - prev_hs == 16, "R10", hs_cyc - prev_hs, 16,
                              "serial accept interval");
                    else
                        check(hs_cyc - prev_hs == 2, "R3", hs_cyc - prev_hs, 2,
                              "parallel accept interval");
                end
                prev_hs = hs_cyc;
            end
            guard = 0;
            while (exp_q.size() != 0 && guard < 4000) begin
                @(negedge clk);
                guard++;
            end
            check(exp_q.size() == 0, row[23] ? "R8" : "R3", exp_q.size(), 0,
                  "bytes still missing at row end");
            exp_q.delete();
            repeat (4) @(negedge clk);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule